// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous static RAM with registered inputs and a registered read path. It is meant to sit as a cache data store behind a host processor or a cache controller. The memory is four byte lanes wide, and each lane carries one parity bit stored next to its byte. Two address-load strobes start an access: one for the host and one for the controller. The access takes effect only when three chip selects are all active. A write can cover all lanes at once or any chosen subset of lanes.

After an access starts, a two-bit burst counter steps through the low address bits whenever the step input is low. The counter follows either a linear or an interleaved order, chosen by a static mode input. Read data leaves through an output register one clock after the read is launched. The data bus is shown as three separate ports: write data in, read data out, and a drive enable. The drive enable is registered and is gated without a clock by the output enable. The bus is released on every write, on every deselect, and in the first cycle of an access that follows a deselect.

Top module: `srb_sram`

## Requirements
- R1: While reset is high and in the cycle after it, `bus_drive` is 0 and `rdata`/`rpar` read 0.
- R2: A read is launched at a rising edge when a strobe is taken, all three chip selects are active (`sel1_n`=0, `sel2`=1, `sel3_n`=0) and no lane is write-enabled. The addressed word appears on `rdata`/`rpar` after the following rising edge. It is driven if `out_en_n` is low.
- R3: A controller-strobe start (`ctl_ld_n`=0, `host_ld_n`=1, chips active) with write controls active writes the word at that same edge.
- R4: On a host-strobe start edge, the write controls and the write data are ignored. At the next edge, the write controls present then write the data to the started address.
- R5: With `wr_all_n` low, all four lanes and all four parity bits are written, whatever `wr_byte_n` and `lane_wr_n` are.
- R6: With `wr_all_n` high, lane i is written only when both `wr_byte_n` and `lane_wr_n[i]` are low. Lane i is `wdata[8i+7:8i]` together with `wpar[i]`. Lanes that are not selected keep their old contents.
- R7: The first cycle of an access started from the deselected state leaves the bus undriven. A new start made while reads are already running keeps driving the previous read data.
- R8: A strobe taken while any chip select is inactive releases the bus after that edge. The block then stays idle.
- R9: Any write edge releases the bus for the following cycle, even when `out_en_n` is low.
- R10: `out_en_n` high forces `bus_drive` low at once, without waiting for a clock edge.
- R11: The host strobe is ignored while `sel1_n` is high. An active burst continues at its current address.
- R12: With `step_n` low in a continuation cycle, the low two address bits advance. With `ilv_order`=0 the order is base+n mod 4. With `ilv_order`=1 it is base XOR n. The upper address bits do not change.
- R13: `step_n` is ignored on a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, sampled on start edges |
| host_ld_n | input | 1 | Host address-load strobe, active low |
| ctl_ld_n | input | 1 | Controller address-load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| sel1_n | input | 1 | Chip select 1, active low; also gates the host strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| lane_wr_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Output enable, active low, unclocked |
| ilv_order | input | 1 | Burst order: 0 linear, 1 interleaved |
| wdata | input | LANES*BYTE_W | Write data bytes |
| wpar | input | LANES | Write parity, one bit per lane |
| rdata | output | LANES*BYTE_W | Registered read data |
| rpar | output | LANES | Registered read parity |
| bus_drive | output | 1 | Tri-state enable for the shared data bus |

## Verification
A table of writes covers the following controls: a whole-word write, a single-lane byte write, lane selects with the byte enable high, the whole-word control overriding cleared byte controls, and a two-lane write into a known word. Reading each word back shows which lanes and parity bits moved. Separate sequences compare two kinds of read start: one from the deselected state (bus released) and one made while reads are running (bus held on old data). They also tell a real deselect apart from a host strobe gated off by chip select 1. Reads of four pre-loaded words in both burst orders, from a base that is neither aligned nor symmetric, separate the linear order from the interleaved order. They also show whether the step input was wrongly honoured on the start edge.

// File: rtl/srb_pkg.sv
package srb_pkg;

  // Action decoded from the control pins at one rising edge
  typedef enum logic [2:0] {
    OP_IDLE,   // nothing selected, nothing started
    OP_DESEL,  // strobe taken with a chip select inactive
    OP_HOST,   // host-strobe start: always launches a read
    OP_CTL,    // controller-strobe start: read or write
    OP_CONT    // continuation of the running burst
  } srb_op_e;

endpackage

// File: rtl/srb_decode.sv
module srb_decode
  import srb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             host_ld_n,
  input  logic             ctl_ld_n,
  input  logic             sel1_n,
  input  logic             sel2,
  input  logic             sel3_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             active,
  output srb_op_e          op,
  output logic [LANES-1:0] lane_mask
);

  logic chips_on;
  logic host_take;
  logic any_strobe;

  always_comb begin
    chips_on   = !sel1_n && sel2 && !sel3_n;
    // host strobe only counts while chip select 1 is active
    host_take  = !host_ld_n && !sel1_n;
    any_strobe = host_take || !ctl_ld_n;

    if (any_strobe && !chips_on)  op = OP_DESEL;
    else if (host_take)           op = OP_HOST;
    else if (!ctl_ld_n)           op = OP_CTL;
    else if (active)              op = OP_CONT;
    else                          op = OP_IDLE;

    // whole-word write overrides the byte controls
    if (!wr_all_n)       lane_mask = '1;
    else if (!wr_byte_n) lane_mask = ~lane_wr_n;
    else                 lane_mask = '0;
  end

endmodule

// File: rtl/srb_burst.sv
module srb_burst #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          ilv,
  input  logic [BW-1:0] base,
  output logic [BW-1:0] eff,
  output logic [BW-1:0] cur
);

  logic [BW-1:0] base_q;
  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_nx;

  function automatic logic [BW-1:0] seq_pos(input logic [BW-1:0] b,
                                            input logic [BW-1:0] n,
                                            input logic          x);
    return x ? (b ^ n) : (b + n);
  endfunction

  always_comb begin
    cnt_nx = step ? cnt_q + BW'(1) : cnt_q;
    cur    = seq_pos(base_q, cnt_q, ilv);
    // address used at this edge: new base on a start, else the stepped slot
    eff    = load ? base : seq_pos(base_q, cnt_nx, ilv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= base;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nx;
    end
  end

endmodule

// File: rtl/srb_array.sv
module srb_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wword,
  input  logic                    rd_en,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rword
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wword[g*LANE_W +: LANE_W];
    end

    // output register of the read pipeline
    always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (rd_en) q <= mem[raddr];
    end

    assign rword[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/srb_sram.sv
module srb_sram
  import srb_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LANES   = 4,
  parameter int BYTE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    host_ld_n,
  input  logic                    ctl_ld_n,
  input  logic                    step_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic                    sel3_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic                    ilv_order,
  input  logic [LANES*BYTE_W-1:0] wdata,
  input  logic [LANES-1:0]        wpar,
  output logic [LANES*BYTE_W-1:0] rdata,
  output logic [LANES-1:0]        rpar,
  output logic                    bus_drive
);

  localparam int LANE_W = BYTE_W + 1;
  localparam int WORD_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - BURST_W;

  srb_op_e           op;
  logic [LANES-1:0]  mask;
  logic              active_q;
  logic              rd_q;
  logic              drive_q;
  logic [HI_W-1:0]   hi_q;
  logic [BURST_W-1:0] eff_lo;
  logic [BURST_W-1:0] cur_lo;
  logic              load;
  logic              step_go;
  logic              wr_slot;
  logic              wr_now;
  logic              rd_launch;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [LANES-1:0]  we;
  logic [WORD_W-1:0] wword;
  logic [WORD_W-1:0] rword;

  srb_decode #(.LANES(LANES)) u_decode (
    .host_ld_n (host_ld_n),
    .ctl_ld_n  (ctl_ld_n),
    .sel1_n    (sel1_n),
    .sel2      (sel2),
    .sel3_n    (sel3_n),
    .wr_all_n  (wr_all_n),
    .wr_byte_n (wr_byte_n),
    .lane_wr_n (lane_wr_n),
    .active    (active_q),
    .op        (op),
    .lane_mask (mask)
  );

  always_comb begin
    load      = (op == OP_HOST) || (op == OP_CTL);
    step_go   = (op == OP_CONT) && !step_n;
    // host starts never write; write controls only count on these slots
    wr_slot   = (op == OP_CTL) || (op == OP_CONT);
    wr_now    = wr_slot && (|mask);
    rd_launch = (op == OP_HOST) || (wr_slot && !(|mask));
    we        = wr_now ? mask : '0;
  end

  srb_burst #(.BW(BURST_W)) u_burst (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .step (step_go),
    .ilv  (ilv_order),
    .base (addr[BURST_W-1:0]),
    .eff  (eff_lo),
    .cur  (cur_lo)
  );

  assign eff_addr = {(load ? addr[ADDR_W-1:BURST_W] : hi_q), eff_lo};
  assign rd_addr  = {hi_q, cur_lo};

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign wword[g*LANE_W +: LANE_W] = {wpar[g], wdata[g*BYTE_W +: BYTE_W]};
    assign rdata[g*BYTE_W +: BYTE_W] = rword[g*LANE_W +: BYTE_W];
    assign rpar[g]                   = rword[g*LANE_W + BYTE_W];
  end

  srb_array #(.LANES(LANES), .LANE_W(LANE_W), .AW(ADDR_W)) u_array (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .waddr (eff_addr),
    .wword (wword),
    .rd_en (rd_q),
    .raddr (rd_addr),
    .rword (rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      drive_q  <= 1'b0;
      hi_q     <= '0;
    end else begin
      if (load) hi_q <= addr[ADDR_W-1:BURST_W];
      case (op)
        OP_DESEL:        active_q <= 1'b0;
        OP_HOST, OP_CTL: active_q <= 1'b1;
        default:         active_q <= active_q;
      endcase
      rd_q    <= rd_launch;
      // drive only data of a read launched one edge ago, never on write/deselect
      drive_q <= rd_q && !wr_now && (op != OP_DESEL);
    end
  end

  assign bus_drive = drive_q && !out_en_n;

endmodule

// File: rtl/srb_sram_chk.sv
module srb_sram_chk (
  input logic clk,
  input logic rst,
  input logic host_ld_n,
  input logic ctl_ld_n,
  input logic sel1_n,
  input logic sel2,
  input logic sel3_n,
  input logic wr_all_n,
  input logic out_en_n,
  input logic bus_drive
);

  logic chips_c, strobe_c, desel_c, host_start_c, ctl_wr_c;

  assign chips_c      = !sel1_n && sel2 && !sel3_n;
  assign strobe_c     = (!host_ld_n && !sel1_n) || !ctl_ld_n;
  assign desel_c      = strobe_c && !chips_c;
  assign host_start_c = !host_ld_n && chips_c;
  assign ctl_wr_c     = !ctl_ld_n && host_ld_n && chips_c && !wr_all_n;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !bus_drive);

  // R8
  desel_release_chk: assert property (@(posedge clk) disable iff (rst)
    desel_c |=> !bus_drive);

  // R9
  write_release_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_c |=> !bus_drive);

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> !bus_drive);

  // R7
  first_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(desel_c) && host_start_c) |=> !bus_drive);

endmodule

bind srb_sram srb_sram_chk i_srb_chk (
  .clk       (clk),
  .rst       (rst),
  .host_ld_n (host_ld_n),
  .ctl_ld_n  (ctl_ld_n),
  .sel1_n    (sel1_n),
  .sel2      (sel2),
  .sel3_n    (sel3_n),
  .wr_all_n  (wr_all_n),
  .out_en_n  (out_en_n),
  .bus_drive (bus_drive)
);

// File: tb/test_srb_sram.sv
`timescale 1ns/1ps
module test_srb_sram;

  localparam int AW = 8;
  localparam int LN = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          host_ld_n = 1'b1, ctl_ld_n = 1'b1, step_n = 1'b1;
  logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
  logic          wr_all_n = 1'b1, wr_byte_n = 1'b1;
  logic [LN-1:0] lane_wr_n = '1;
  logic          out_en_n = 1'b0, ilv_order = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [LN-1:0] wpar = '0;
  logic [DW-1:0] rdata;
  logic [LN-1:0] rpar;
  logic          bus_drive;

  srb_sram #(.ADDR_W(AW), .LANES(LN), .BYTE_W(8), .BURST_W(2)) i_srb_sram (
    .clk(clk), .rst(rst), .addr(addr), .host_ld_n(host_ld_n), .ctl_ld_n(ctl_ld_n),
    .step_n(step_n), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_wr_n(lane_wr_n),
    .out_en_n(out_en_n), .ilv_order(ilv_order), .wdata(wdata), .wpar(wpar),
    .rdata(rdata), .rpar(rpar), .bus_drive(bus_drive)
  );

  always #10 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [35:0] model [256];

  // {kind(0 ctl,1 host), addr, wr_all_n, wr_byte_n, lane_wr_n, {par,data}}
  localparam logic [50:0] VEC [0:7] = '{
    {1'b0, 8'h10, 1'b0, 1'b1, 4'hF,    36'h9_1234_5678}, // R3 R5 whole word
    {1'b0, 8'h10, 1'b1, 1'b0, 4'b1011, 36'hF_AABB_CCDD}, // R6 lane 2 only
    {1'b0, 8'h10, 1'b1, 1'b1, 4'h0,    36'h0_0000_0000}, // R6 selects without enable
    {1'b1, 8'h20, 1'b0, 1'b1, 4'hF,    36'hA_5A5A_5A5A}, // R4 host whole word
    {1'b1, 8'h20, 1'b1, 1'b0, 4'b1110, 36'h1_0000_00FF}, // R4 R6 lane 0
    {1'b0, 8'h21, 1'b0, 1'b0, 4'h0,    36'h3_0F0F_0F0F}, // R5 override
    {1'b0, 8'h22, 1'b0, 1'b1, 4'hF,    36'h6_C3C3_C3C3}, // R3 whole word
    {1'b0, 8'h22, 1'b1, 1'b0, 4'b0101, 36'h9_1111_2222}  // R6 lanes 1 and 3
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] word_out();
    return {rpar, rdata};
  endfunction

  function automatic logic [35:0] drv();
    return {35'd0, bus_drive};
  endfunction

  task automatic nop();
    host_ld_n = 1'b1; ctl_ld_n = 1'b1; step_n = 1'b1;
    sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_wr_n = '1;
    out_en_n = 1'b0; ilv_order = 1'b0; wdata = '0; wpar = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic desel();
    nop(); ctl_ld_n = 1'b0; sel1_n = 1'b1;
    step();
    chk("R8 deselect releases bus", drv(), 36'd0);
    nop();
  endtask

  task automatic model_upd(input logic [7:0] a, input logic wa, input logic wb,
                           input logic [3:0] ln, input logic [35:0] d);
    for (int i = 0; i < LN; i++) begin
      if (!wa || (!wb && !ln[i])) begin
        model[a][i*8 +: 8] = d[i*8 +: 8];
        model[a][32+i]     = d[32+i];
      end
    end
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic wa, input logic wb,
                           input logic [3:0] ln, input logic [35:0] d);
    nop(); ctl_ld_n = 1'b0; addr = a;
    wr_all_n = wa; wr_byte_n = wb; lane_wr_n = ln; {wpar, wdata} = d;
    step();
    model_upd(a, wa, wb, ln, d);
    desel();
  endtask

  task automatic host_write(input logic [7:0] a, input logic wa, input logic wb,
                            input logic [3:0] ln, input logic [35:0] d);
    nop(); host_ld_n = 1'b0; addr = a;
    wr_all_n = 1'b0; {wpar, wdata} = ~d;   // ignored on the start edge
    step();
    nop(); wr_all_n = wa; wr_byte_n = wb; lane_wr_n = ln; {wpar, wdata} = d;
    step();
    chk("R9 R4 bus released on host write edge", drv(), 36'd0);
    model_upd(a, wa, wb, ln, d);
    desel();
  endtask

  task automatic read_check(input logic [7:0] a, input string tag);
    nop(); host_ld_n = 1'b0; addr = a;
    step();
    chk("R7 first cycle after deselect undriven", drv(), 36'd0);
    nop();
    step();
    chk(tag, word_out(), model[a]);
    chk("R2 read data driven", drv(), 36'd1);
    desel();
  endtask

  task automatic burst_run(input logic ilv);
    logic [1:0] lo;
    nop(); ilv_order = ilv; host_ld_n = 1'b0; addr = 8'h41; step_n = 1'b0;
    step();
    nop(); ilv_order = ilv; step_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      lo = ilv ? (2'd1 ^ 2'(k)) : (2'd1 + 2'(k));
      if (k == 0) chk("R13 step ignored on start edge", word_out(), model[{6'h10, lo}]);
      else        chk("R12 burst order", word_out(), model[{6'h10, lo}]);
    end
    desel();
  endtask

  initial begin
    #(64'd200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    nop();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 bus undriven in reset", drv(), 36'd0);
    rst = 1'b0;
    step();
    chk("R1 bus undriven after reset", drv(), 36'd0);
    chk("R1 read register cleared", word_out(), 36'd0);

    // table walk: each write followed by a read-back
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][50])
        host_write(VEC[v][49:42], VEC[v][41], VEC[v][40], VEC[v][39:36], VEC[v][35:0]);
      else
        ctl_write(VEC[v][49:42], VEC[v][41], VEC[v][40], VEC[v][39:36], VEC[v][35:0]);
      read_check(VEC[v][49:42], "R3 R4 R5 R6 read-back");
    end

    // consecutive reads, output enable, gated host strobe, write, deselect
    nop(); host_ld_n = 1'b0; addr = 8'h10;
    step();
    nop();
    step();
    chk("R2 read of 0x10", word_out(), model[8'h10]);
    out_en_n = 1'b1; #2;
    chk("R10 output enable high releases bus", drv(), 36'd0);
    out_en_n = 1'b0; #2;
    chk("R10 output enable low drives bus", drv(), 36'd1);
    host_ld_n = 1'b0; addr = 8'h21;
    step();
    chk("R7 new start while reading keeps old data", word_out(), model[8'h10]);
    chk("R7 new start while reading keeps driving", drv(), 36'd1);
    nop();
    step();
    chk("R2 read of 0x21", word_out(), model[8'h21]);
    nop(); host_ld_n = 1'b0; sel1_n = 1'b1; addr = 8'h10;
    step();
    chk("R11 gated host strobe keeps burst", word_out(), model[8'h21]);
    chk("R11 gated host strobe keeps driving", drv(), 36'd1);
    nop();
    step();
    chk("R11 address unchanged", word_out(), model[8'h21]);
    nop(); wr_all_n = 1'b0; {wpar, wdata} = 36'h7_7654_3210;
    step();
    chk("R9 write edge releases bus", drv(), 36'd0);
    model_upd(8'h21, 1'b0, 1'b1, 4'hF, 36'h7_7654_3210);
    nop();
    step();
    nop();
    step();
    chk("R9 continuation write landed", word_out(), model[8'h21]);
    nop(); host_ld_n = 1'b0; sel2 = 1'b0;
    step();
    chk("R8 chip select 2 low deselects", drv(), 36'd0);
    nop();
    step();
    chk("R8 stays idle", drv(), 36'd0);

    // host start ignores write controls
    nop(); host_ld_n = 1'b0; addr = 8'h20; wr_all_n = 1'b0; wdata = '0; wpar = '0;
    step();
    nop();
    step();
    chk("R4 start-edge write ignored", word_out(), model[8'h20]);
    chk("R4 start edge launched a read", drv(), 36'd1);
    desel();

    // controller-strobe read
    nop(); ctl_ld_n = 1'b0; addr = 8'h22;
    step();
    nop();
    step();
    chk("R2 controller-strobe read", word_out(), model[8'h22]);
    desel();

    // burst orders
    for (int i = 0; i < 4; i++)
      ctl_write(8'h40 + 8'(i), 1'b0, 1'b1, 4'hF, 36'h5_4040_0000 + 36'(i * 16'h0101));
    burst_run(1'b0);
    burst_run(1'b1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule